// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog Reset

This block is a memory-mapped system timer. A 32-bit up-counter advances by one on each reference tick, nominally at 3.6864 MHz, and four match channels compare the counter against their own compare registers. When the counter steps onto a channel's compare value and that channel is enabled, the channel's status bit latches and its interrupt line goes high. Software clears the bit by writing a one to it.

Channel 3 also acts as a watchdog. If software has armed the watchdog, a match on channel 3 produces a one-cycle reset request and disarms the watchdog, whether or not the channel 3 interrupt is enabled. Software keeps the system alive by moving the channel 3 compare value ahead of the counter before it gets there.

The tick comes from an input strobe. With `DIV_RATIO` left at 0 each strobe is one tick. A nonzero `DIV_RATIO` selects an internal divider that produces one tick for every `DIV_RATIO` strobes. Register reads return data one cycle after the address is presented.

Top module: `ostm_match4`

## Requirements
- R1: After reset the counter, all compare registers, the interrupt-enable register, the watchdog-arm register and the status register read zero, and `irq` and `wdog_rst` are low.
- R2: The counter (offset 0x10) increases by one on each clock edge where the tick is high, holds its value otherwise, and wraps from 0xFFFFFFFF to 0.
- R3: A write to offset 0x10 loads the written value, and counting continues from it. A load in the same cycle as a tick takes precedence, so that tick is lost.
- R4: When a tick moves the counter onto a channel's compare value (channel i at offset 4*i) and bit i of the interrupt-enable register is set, status bit i and `irq[i]` go high at that same clock edge. A channel whose enable bit is clear sets nothing.
- R5: The status register (offset 0x14, bit i for channel i) is write-one-to-clear. Clearing bit i lowers `irq[i]`, and writing zeros has no effect. If a new match arrives in the same cycle as the clear, the bit stays set.
- R6: The interrupt-enable register (offset 0x1C) stores only its low 12 bits. Bits 31:12 read zero.
- R7: If bit 0 of the watchdog-arm register (offset 0x18) is set when channel 3 matches, `wdog_rst` is high for exactly one cycle and the arm bit clears. This does not depend on the channel 3 interrupt enable.
- R8: Reads of offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C return zero. Writes to those other offsets change no register.
- R9: Compare registers read back what was written. A match fires only on the tick that reaches the compare value, so a counter resting on that value raises nothing further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Reference tick strobe (divider input when DIV_RATIO > 0) |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Registered read data for the previous cycle's address |
| irq | output | NUM_CH | Per-channel interrupt lines |
| wdog_rst | output | 1 | One-cycle watchdog reset request |

## Verification
Two pairs of functions can land in the same cycle. In the first pair, a software write-one-to-clear on a status bit arrives together with a tick that makes the same channel match again. The bench drives the clear write and the tick strobe in one cycle and expects the bit and its interrupt to stay high. In the second pair, a counter load coincides with a tick. The bench reads the counter back and expects exactly the loaded value, with no extra increment.

// File: rtl/ostm_pkg.sv
package ostm_pkg;
  // Register byte offsets decoded by the top module
  localparam int unsigned OFS_CNT  = 'h10;
  localparam int unsigned OFS_STAT = 'h14;
  localparam int unsigned OFS_WDOG = 'h18;
  localparam int unsigned OFS_IEN  = 'h1C;
  // Compare register of channel i sits at CMP_STRIDE * i
  localparam int unsigned CMP_STRIDE = 4;
endpackage

// File: rtl/ostm_tick_gen.sv
module ostm_tick_gen #(
  parameter int unsigned DIV_RATIO = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  output logic tick
);
  generate
    if (DIV_RATIO == 0) begin : g_direct
      assign tick = tick_in;
    end else begin : g_div
      localparam int unsigned DW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
      localparam logic [DW-1:0] LAST = DW'(DIV_RATIO - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else if (tick_in) div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
      end
      assign tick = tick_in && (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/ostm_counter.sv
module ostm_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_inc
);
  assign cnt_inc = cnt_q + 1'b1;
  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (adv)  cnt_q <= cnt_inc;
  end
endmodule

// File: rtl/ostm_channel.sv
module ostm_channel #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             adv,
  input  logic [CNT_W-1:0] cnt_inc,
  output logic [CNT_W-1:0] cmp_q,
  output logic             hit
);
  always_ff @(posedge clk) begin
    if (rst)     cmp_q <= '0;
    else if (wr) cmp_q <= wdata;
  end
  // Match only on the tick that steps the counter onto the compare value
  assign hit = adv && (cnt_inc == cmp_q);
endmodule

// File: rtl/ostm_match4.sv
module ostm_match4 import ostm_pkg::*; #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned IEN_W     = 12,
  parameter int unsigned DIV_RATIO = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic [NUM_CH-1:0] irq,
  output logic              wdog_rst
);
  localparam int unsigned WDOG_CH = NUM_CH - 1;

  logic              tick_pulse;
  logic              cnt_load;
  logic              cnt_adv;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_inc;
  logic [CNT_W-1:0]  cmp_arr [NUM_CH];
  logic [NUM_CH-1:0] hit_vec;
  logic [NUM_CH-1:0] stat_q;
  logic [IEN_W-1:0]  ien_q;
  logic              warm_q;
  logic              wdog_q;
  logic [CNT_W-1:0]  rd_q;
  logic              stat_wr, ien_wr, warm_wr;

  assign cnt_load = wr_en && (addr == ADDR_W'(OFS_CNT));
  assign stat_wr  = wr_en && (addr == ADDR_W'(OFS_STAT));
  assign ien_wr   = wr_en && (addr == ADDR_W'(OFS_IEN));
  assign warm_wr  = wr_en && (addr == ADDR_W'(OFS_WDOG));
  assign cnt_adv  = tick_pulse && !cnt_load;

  ostm_tick_gen #(.DIV_RATIO(DIV_RATIO)) u_tick (
    .clk(clk), .rst(rst), .tick_in(tick_in), .tick(tick_pulse)
  );

  ostm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(wdata),
    .adv(cnt_adv), .cnt_q(cnt_q), .cnt_inc(cnt_inc)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      ostm_channel #(.CNT_W(CNT_W)) u_ch (
        .clk(clk), .rst(rst),
        .wr(wr_en && (addr == ADDR_W'(CMP_STRIDE * i))),
        .wdata(wdata), .adv(cnt_adv), .cnt_inc(cnt_inc),
        .cmp_q(cmp_arr[i]), .hit(hit_vec[i])
      );
      // Set wins over a same-cycle write-one-to-clear
      always_ff @(posedge clk) begin
        if (rst) stat_q[i] <= 1'b0;
        else if (hit_vec[i] && ien_q[i]) stat_q[i] <= 1'b1;
        else if (stat_wr && wdata[i]) stat_q[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= '0;
      warm_q <= 1'b0;
      wdog_q <= 1'b0;
    end else begin
      if (ien_wr) ien_q <= wdata[IEN_W-1:0];
      wdog_q <= hit_vec[WDOG_CH] && warm_q;
      if (hit_vec[WDOG_CH] && warm_q) warm_q <= 1'b0;
      else if (warm_wr)               warm_q <= wdata[0];
    end
  end

  always_comb begin
    rd_q = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr == ADDR_W'(CMP_STRIDE * i)) rd_q = cmp_arr[i];
    if (addr == ADDR_W'(OFS_CNT))  rd_q = cnt_q;
    if (addr == ADDR_W'(OFS_STAT)) rd_q = CNT_W'(stat_q);
    if (addr == ADDR_W'(OFS_WDOG)) rd_q = CNT_W'(warm_q);
    if (addr == ADDR_W'(OFS_IEN))  rd_q = CNT_W'(ien_q);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_q;
  end

  assign irq      = stat_q;
  assign wdog_rst = wdog_q;
endmodule

// File: rtl/ostm_match4_checks.sv
module ostm_match4_checks import ostm_pkg::*; #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned IEN_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata,
  input logic              tick_pulse,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [NUM_CH-1:0] hit_vec,
  input logic [IEN_W-1:0]  ien_q,
  input logic [NUM_CH-1:0] irq,
  input logic              wdog_rst
);
  // R2: no tick and no load leaves the counter unchanged
  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick_pulse && !(wr_en && addr == ADDR_W'(OFS_CNT))) |=> $stable(cnt_q));

  // R3: a load puts the written value into the counter
  assert_cnt_load_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFS_CNT)) |=> (cnt_q == $past(wdata)));

  // R4: an interrupt line only rises for a channel that was enabled
  assert_irq_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    ((irq & ~$past(irq) & ~$past(ien_q[NUM_CH-1:0])) == '0));

  // R5: a clear with no new match drops the written bits
  assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFS_STAT) && hit_vec == '0)
      |=> ((irq & $past(wdata[NUM_CH-1:0])) == '0));

  // R7: the watchdog request lasts a single cycle
  assert_wdog_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    wdog_rst |=> !wdog_rst);
endmodule

bind ostm_match4 ostm_match4_checks #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .IEN_W(IEN_W)
) u_checks (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .tick_pulse(tick_pulse), .cnt_q(cnt_q), .hit_vec(hit_vec),
  .ien_q(ien_q), .irq(irq), .wdog_rst(wdog_rst)
);

// File: tb/ostm_match4_bench.sv
module ostm_match4_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;
  logic        wdog_rst;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ostm_match4 u_ostm_match4 (
    .clk(clk), .rst(rst), .tick_in(tick_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .wdog_rst(wdog_rst)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_in = 1'b1;
    repeat (n) @(negedge clk);
    tick_in = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h10, v); chk("R1 counter", v, 0);
    rd(8'h14, v); chk("R1 status", v, 0);
    rd(8'h1C, v); chk("R1 ien", v, 0);
    rd(8'h18, v); chk("R1 wdog arm", v, 0);
    rd(8'h0C, v); chk("R1 cmp3", v, 0);
    chk("R1 irq", {28'd0, irq}, 0);
    chk("R1 wdog_rst", {31'd0, wdog_rst}, 0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    ticks(5);
    rd(8'h10, v); chk("R2 count 5", v, 5);
    repeat (3) @(negedge clk);
    rd(8'h10, v); chk("R2 hold", v, 5);
    wr(8'h10, 32'hFFFF_FFFE);
    ticks(3);
    rd(8'h10, v); chk("R2 wrap", v, 1);
  endtask

  task automatic t_load_vs_tick;
    logic [31:0] v;
    @(negedge clk); wr_en = 1'b1; addr = 8'h10; wdata = 100; tick_in = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick_in = 1'b0;
    rd(8'h10, v); chk("R3 load wins", v, 100);
    ticks(2);
    rd(8'h10, v); chk("R3 continue", v, 102);
  endtask

  task automatic t_match;
    logic [31:0] v;
    wr(8'h1C, 32'h1);
    wr(8'h00, 110);
    wr(8'h04, 105);
    wr(8'h10, 100);
    ticks(5);
    chk("R4 disabled ch1 irq", {28'd0, irq}, 0);
    rd(8'h14, v); chk("R4 disabled ch1 status", v, 0);
    ticks(4);
    chk("R4 before match", {28'd0, irq}, 0);
    ticks(1);
    chk("R4 match irq", {28'd0, irq}, 1);
    rd(8'h14, v); chk("R4 status", v, 1);
    wr(8'h14, 32'h0);
    chk("R5 zero write", {28'd0, irq}, 1);
    wr(8'h14, 32'h1);
    chk("R5 clear", {28'd0, irq}, 0);
    repeat (3) @(negedge clk);
    chk("R9 no refire", {28'd0, irq}, 0);
    rd(8'h00, v); chk("R9 cmp0", v, 110);
    rd(8'h04, v); chk("R9 cmp1", v, 105);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    wr(8'h00, 119);
    wr(8'h10, 118);
    ticks(1);
    chk("R4 set", {28'd0, irq}, 1);
    wr(8'h00, 120);
    @(negedge clk); wr_en = 1'b1; addr = 8'h14; wdata = 32'h1; tick_in = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick_in = 1'b0;
    chk("R5 set beats clear", {28'd0, irq}, 1);
    rd(8'h10, v); chk("R2 collision count", v, 120);
    wr(8'h14, 32'hF);
    chk("R5 final clear", {28'd0, irq}, 0);
  endtask

  task automatic t_ien;
    logic [31:0] v;
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, v); chk("R6 ien width", v, 32'h0000_0FFF);
    wr(8'h1C, 32'h0);
  endtask

  task automatic t_unknown;
    logic [31:0] v;
    wr(8'h20, 32'hDEAD_BEEF);
    wr(8'h30, 32'h1234_5678);
    rd(8'h20, v); chk("R8 read 0x20", v, 0);
    rd(8'h24, v); chk("R8 read 0x24", v, 0);
    rd(8'h00, v); chk("R8 cmp0 untouched", v, 120);
    rd(8'h10, v); chk("R8 counter untouched", v, 120);
    rd(8'h08, v); chk("R9 cmp2 zero", v, 0);
  endtask

  task automatic t_wdog;
    logic [31:0] v;
    wr(8'h0C, 200);
    wr(8'h18, 32'h1);
    rd(8'h18, v); chk("R7 armed", v, 1);
    wr(8'h10, 198);
    ticks(1);
    chk("R7 no early pulse", {31'd0, wdog_rst}, 0);
    ticks(1);
    chk("R7 pulse", {31'd0, wdog_rst}, 1);
    @(negedge clk);
    chk("R7 one cycle", {31'd0, wdog_rst}, 0);
    chk("R7 ch3 irq off", {28'd0, irq}, 0);
    rd(8'h18, v); chk("R7 disarmed", v, 0);
    wr(8'h10, 199);
    ticks(1);
    chk("R7 no pulse when disarmed", {31'd0, wdog_rst}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_count;
    t_load_vs_tick;
    t_match;
    t_collision;
    t_ien;
    t_unknown;
    t_wdog;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule